// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar for a real-time clock. A one-cycle enable that arrives once per second advances it. It holds seconds, minutes and hours in BCD, with hours in 24-hour form. It also holds a 3-bit day of week and a BCD date, month and two-digit year. The fields form one cascade. A field that passes its last legal value returns to its first value and advances the next field. The last legal date is worked out from the current month and from a leap-year rule that runs on the BCD digits of the year.

A host loads any field through a simple write port and reads any field back through a combinational read port. Both ports use the same 3-bit field code. A sticky flag records that time integrity is lost. Reset sets it, and so does a pulse on the oscillator-fail input. Only a host write clears it. The oscillator, the prescaler that makes the second tick and the serial bus that drives the host ports are outside this block.

Top module: `rtc_calendar_core`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. A tick that finds a field at 59 returns it to 00 and advances the next field.
- R2: Hours count 00 to 23 in BCD. A tick that carries out of the hours at 23 returns them to 00 and advances both the date and the day of week.
- R3: The day of week is a 3-bit counter that goes 0,1,...,6 and then back to 0. It is read on bits [2:0] of the read data, and the upper bits read 0.
- R4: The last date is 31 (BCD) for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. A date carry returns the date to 01 and advances the month.
- R5: In month 02 the last date is 29 in a leap year and 28 otherwise. A year is a leap year when its two-digit value is a multiple of 4, 00 included. This is decided on the digits: an even tens digit with a units digit of 0, 4 or 8, or an odd tens digit with a units digit of 2 or 6.
- R6: The month counts 01 to 12 and carries into the year when it returns to 01. The year counts 00 to 99 and returns to 00.
- R7: Without a tick, every field holds its value.
- R8: When wr_en_i is high, wr_data_i loads the field chosen by wr_sel_i. The codes are 0 seconds, 1 minutes, 2 hours, 3 day of week (bits [2:0]), 4 date, 5 month and 6 year. A write cycle drops any tick in that cycle for all fields.
- R9: rd_data_o shows the field chosen by rd_sel_i in the same cycle, using the same codes. Code 7 returns the oscillator-fail flag on bit 0 and 0 on bits [7:1].
- R10: The oscillator-fail flag is set by reset and by osc_fail_i. It stays set until a write with code 7 and wr_data_i[0] = 0. When a set and a clear fall in the same cycle, the set wins. A code-7 write with wr_data_i[0] = 1 does not change the flag.
- R11: A field loaded with a value at or above its last legal value (digits above 9 included) returns to its first value on the next tick that reaches it, and it carries. A day of week of 7 returns to 0.
- R12: After reset the state is 00:00:00, day of week 0, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle once-per-second advance enable |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Field code for the write |
| wr_data_i | input | 8 | Write data (BCD for time and date fields) |
| osc_fail_i | input | 1 | Pulse that marks the oscillator as failed |
| rd_sel_i | input | 3 | Field code for the read |
| rd_data_o | output | 8 | Value of the selected field |

## Verification
The hardest cases to reach are the end-of-month carries. Each one needs a full cascade from seconds through hours into the date, on one particular month and year. Reaching one by ticking alone would take days of simulated seconds. The bench loads the fields to 23:59:59 on the last date of a month and then gives one tick. It sweeps every month, and it sweeps February over all hundred two-digit years. The expected date, month and year come from arithmetic on the year value. A separate run of more than an hour of plain ticks checks the seconds and minutes cascade against a counter in the bench.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int BCD_W    = 8;
    localparam int WDAY_W   = 3;
    localparam int SEL_W    = 3;
    localparam int N_BCD    = 6;
    localparam logic [WDAY_W-1:0] WDAY_LAST = 3'd6;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC    = 3'd0,
        SEL_MIN    = 3'd1,
        SEL_HOUR   = 3'd2,
        SEL_WDAY   = 3'd3,
        SEL_DATE   = 3'd4,
        SEL_MONTH  = 3'd5,
        SEL_YEAR   = 3'd6,
        SEL_STATUS = 3'd7
    } field_sel_e;

    typedef struct packed {
        bcd_t              year;
        bcd_t              month;
        bcd_t              date;
        logic [WDAY_W-1:0] wday;
        bcd_t              hour;
        bcd_t              min;
        bcd_t              sec;
    } cal_time_t;

    // Chain index of each BCD field: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year
    function automatic field_sel_e chain_sel(input int idx);
        return (idx < 3) ? field_sel_e'(idx) : field_sel_e'(idx + 1);
    endfunction

    function automatic bcd_t chain_low(input int idx);
        return (idx == 3 || idx == 4) ? 8'h01 : 8'h00;
    endfunction

    function automatic bcd_t chain_fixed_max(input int idx);
        case (idx)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            4:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    function automatic bcd_t bcd_next(input bcd_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_bcd(input bcd_t yr);
        if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic bcd_t last_date_bcd(input bcd_t mon, input bcd_t yr);
        case (mon)
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter bcd_t LOW = 8'h00
) (
    input  logic clk,
    input  logic rst,
    input  logic inc_i,
    input  logic ld_i,
    input  bcd_t ld_val_i,
    input  bcd_t max_i,
    output bcd_t val_o,
    output logic wrap_o
);
    bcd_t val_q;
    logic at_end;

    assign at_end = (val_q >= max_i);
    assign wrap_o = inc_i && at_end;
    assign val_o  = val_q;

    always_ff @(posedge clk) begin
        if (rst)        val_q <= LOW;
        else if (ld_i)  val_q <= ld_val_i;
        else if (inc_i) val_q <= at_end ? LOW : bcd_next(val_q);
    end
endmodule

// File: rtl/rtc_wday_ctr.sv
module rtc_wday_ctr
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_i,
    input  logic              ld_i,
    input  logic [WDAY_W-1:0] ld_val_i,
    output logic [WDAY_W-1:0] val_o
);
    logic [WDAY_W-1:0] val_q;

    always_ff @(posedge clk) begin
        if (rst)        val_q <= '0;
        else if (ld_i)  val_q <= ld_val_i;
        else if (inc_i) val_q <= (val_q >= WDAY_LAST) ? '0 : val_q + 1'b1;
    end

    assign val_o = val_q;
endmodule

// File: rtl/rtc_osc_flag.sv
module rtc_osc_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b1;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [BCD_W-1:0] wr_data_i,
    input  logic             osc_fail_i,
    input  logic [SEL_W-1:0] rd_sel_i,
    output logic [BCD_W-1:0] rd_data_o
);
    logic              adv;
    bcd_t              val  [N_BCD];
    bcd_t              lim  [N_BCD];
    logic              inc  [N_BCD];
    logic              wrap [N_BCD];
    logic [WDAY_W-1:0] wday;
    logic              osc_flag_q;
    cal_time_t         cur;

    // A write cycle swallows the tick so a partial update never mixes with a carry
    assign adv = tick_i && !wr_en_i;

    generate
        for (genvar i = 0; i < N_BCD; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign inc[i] = adv;
            end else begin : g_next
                assign inc[i] = wrap[i-1];
            end

            if (i == 3) begin : g_date_lim
                assign lim[i] = last_date_bcd(val[4], val[5]);
            end else begin : g_fixed_lim
                assign lim[i] = chain_fixed_max(i);
            end

            rtc_bcd_field #(.LOW(chain_low(i))) i_field (
                .clk      (clk),
                .rst      (rst),
                .inc_i    (inc[i]),
                .ld_i     (wr_en_i && (field_sel_e'(wr_sel_i) == chain_sel(i))),
                .ld_val_i (wr_data_i),
                .max_i    (lim[i]),
                .val_o    (val[i]),
                .wrap_o   (wrap[i])
            );
        end
    endgenerate

    rtc_wday_ctr i_wday (
        .clk      (clk),
        .rst      (rst),
        .inc_i    (wrap[2]),
        .ld_i     (wr_en_i && (field_sel_e'(wr_sel_i) == SEL_WDAY)),
        .ld_val_i (wr_data_i[WDAY_W-1:0]),
        .val_o    (wday)
    );

    rtc_osc_flag i_osc (
        .clk    (clk),
        .rst    (rst),
        .set_i  (osc_fail_i),
        .clr_i  (wr_en_i && (field_sel_e'(wr_sel_i) == SEL_STATUS) && !wr_data_i[0]),
        .flag_o (osc_flag_q)
    );

    assign cur = '{year: val[5], month: val[4], date: val[3], wday: wday,
                   hour: val[2], min: val[1], sec: val[0]};

    always_comb begin
        case (field_sel_e'(rd_sel_i))
            SEL_SEC:   rd_data_o = cur.sec;
            SEL_MIN:   rd_data_o = cur.min;
            SEL_HOUR:  rd_data_o = cur.hour;
            SEL_WDAY:  rd_data_o = {{(BCD_W-WDAY_W){1'b0}}, cur.wday};
            SEL_DATE:  rd_data_o = cur.date;
            SEL_MONTH: rd_data_o = cur.month;
            SEL_YEAR:  rd_data_o = cur.year;
            default:   rd_data_o = {{(BCD_W-1){1'b0}}, osc_flag_q};
        endcase
    end
endmodule

// File: rtl/rtc_calendar_sva.sv
module rtc_calendar_sva
    import rtc_cal_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             wr_en_i,
    input logic [SEL_W-1:0] wr_sel_i,
    input logic [BCD_W-1:0] wr_data_i,
    input logic             osc_fail_i,
    input logic             osc_flag_q,
    input cal_time_t        cur
);
    logic adv, eod;
    assign adv = tick_i && !wr_en_i;
    assign eod = adv && cur.sec == 8'h59 && cur.min == 8'h59 && cur.hour == 8'h23;

    p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (adv && cur.sec == 8'h59 && cur.min == 8'h10) |=> (cur.sec == 8'h00 && cur.min == 8'h11));

    p_hour_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        eod |=> (cur.hour == 8'h00 && cur.min == 8'h00 && cur.sec == 8'h00));

    p_wday_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (eod && cur.wday == 3'd6) |=> (cur.wday == 3'd0));

    p_april_end_r4: assert property (@(posedge clk) disable iff (rst)
        (eod && cur.date == 8'h30 && cur.month == 8'h04) |=> (cur.date == 8'h01 && cur.month == 8'h05));

    p_feb_common_r5: assert property (@(posedge clk) disable iff (rst)
        (eod && cur.date == 8'h28 && cur.month == 8'h02 && cur.year == 8'h01)
        |=> (cur.date == 8'h01 && cur.month == 8'h03));

    p_year_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (eod && cur.date == 8'h31 && cur.month == 8'h12 && cur.year == 8'h99)
        |=> (cur.year == 8'h00 && cur.month == 8'h01 && cur.date == 8'h01));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !wr_en_i) |=> $stable(cur));

    p_write_min_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_sel_i == 3'd1) |=> (cur.min == $past(wr_data_i) && $stable(cur.sec)));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (osc_flag_q && !(wr_en_i && wr_sel_i == 3'd7 && !wr_data_i[0])) |=> osc_flag_q);

    p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
        osc_fail_i |=> osc_flag_q);
endmodule

bind rtc_calendar_core rtc_calendar_sva i_sva (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .osc_fail_i (osc_fail_i),
    .osc_flag_q (osc_flag_q),
    .cur        (cur)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = '0;
    logic [7:0] wr_data_i = '0;
    logic       osc_fail_i = 1'b0;
    logic [2:0] rd_sel_i = '0;
    logic [7:0] rd_data_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .osc_fail_i(osc_fail_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
    );

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int days_in(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input int sel, output logic [7:0] v);
        rd_sel_i = 3'(sel);
        #1;
        v = rd_data_o;
    endtask

    task automatic expect_field(input string req, input int sel, input logic [7:0] exp);
        logic [7:0] v;
        rd(sel, v);
        check(req, v, exp);
    endtask

    task automatic wr(input int sel, input logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic tick;
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] y, mo, d, h, mi, s);
        wr(6, y); wr(5, mo); wr(4, d); wr(2, h); wr(1, mi); wr(0, s);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state, R10 flag set by reset
        expect_field("R12 sec", 0, 8'h00);
        expect_field("R12 min", 1, 8'h00);
        expect_field("R12 hour", 2, 8'h00);
        expect_field("R12 wday", 3, 8'h00);
        expect_field("R12 date", 4, 8'h01);
        expect_field("R12 month", 5, 8'h01);
        expect_field("R12 year", 6, 8'h00);
        expect_field("R10 flag after reset", 7, 8'h01);

        // R7 hold without tick
        repeat (6) @(negedge clk);
        expect_field("R7 hold sec", 0, 8'h00);

        // R1 seconds/minutes cascade over more than an hour
        set_time(8'h05, 8'h06, 8'h15, 8'h10, 8'h00, 8'h00);
        for (int k = 1; k <= 3700; k++) begin
            tick();
            expect_field("R1 sec", 0, to_bcd(k % 60));
            expect_field("R1 min", 1, to_bcd((k / 60) % 60));
        end
        expect_field("R2 hour carry from minutes", 2, 8'h11);

        // R2 hour wraps and advances date
        set_time(8'h05, 8'h06, 8'h15, 8'h22, 8'h59, 8'h59);
        tick();
        expect_field("R2 hour 22->23", 2, 8'h23);
        expect_field("R2 date unchanged", 4, 8'h15);
        wr(1, 8'h59); wr(0, 8'h59);
        tick();
        expect_field("R2 hour 23->00", 2, 8'h00);
        expect_field("R2 date advanced", 4, 8'h16);

        // R3 weekday sweep over ten day rollovers
        wr(3, 8'h03);
        for (int k = 1; k <= 10; k++) begin
            wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59); wr(4, 8'h10);
            tick();
            expect_field("R3 wday", 3, 8'((3 + k) % 7));
        end

        // R4/R6 end of every month in year 01, then December 99
        for (int m = 1; m <= 12; m++) begin
            set_time(8'h01, to_bcd(m), to_bcd(days_in(m, 1)), 8'h23, 8'h59, 8'h59);
            tick();
            expect_field("R4 date to 01", 4, 8'h01);
            expect_field("R4 month advance", 5, to_bcd(m % 12 + 1));
            expect_field("R6 year", 6, (m == 12) ? 8'h02 : 8'h01);
        end
        set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        tick();
        expect_field("R6 year 99->00", 6, 8'h00);
        expect_field("R6 month 12->01", 5, 8'h01);

        // R5 February over all hundred years
        for (int y = 0; y < 100; y++) begin
            set_time(to_bcd(y), 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
            tick();
            expect_field("R5 feb 28 next date", 4, (y % 4 == 0) ? 8'h29 : 8'h01);
            expect_field("R5 feb 28 next month", 5, (y % 4 == 0) ? 8'h02 : 8'h03);
            if (y % 4 == 0) begin
                wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
                tick();
                expect_field("R5 feb 29 next date", 4, 8'h01);
                expect_field("R5 feb 29 next month", 5, 8'h03);
            end
        end

        // R8 write wins over a same-cycle tick, which is dropped
        set_time(8'h10, 8'h03, 8'h03, 8'h08, 8'h10, 8'h59);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h22; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        expect_field("R8 written min", 1, 8'h22);
        expect_field("R8 tick dropped sec", 0, 8'h59);
        wr(3, 8'hF5);
        expect_field("R8 wday low bits", 3, 8'h05);

        // R11 illegal values recover
        wr(0, 8'h7A); wr(1, 8'h30);
        tick();
        expect_field("R11 sec illegal to 00", 0, 8'h00);
        expect_field("R11 carry into min", 1, 8'h31);
        wr(0, 8'h3F);
        tick();
        expect_field("R11 bad units digit", 0, 8'h40);
        wr(2, 8'h25); wr(1, 8'h59); wr(0, 8'h59); wr(3, 8'h07);
        tick();
        expect_field("R11 hour illegal to 00", 2, 8'h00);
        expect_field("R11 wday 7 to 0", 3, 8'h00);

        // R10/R9 oscillator-fail flag
        wr(7, 8'h00);
        expect_field("R10 flag cleared", 7, 8'h00);
        @(negedge clk); osc_fail_i = 1'b1;
        @(negedge clk); osc_fail_i = 1'b0;
        expect_field("R10 flag set by fail", 7, 8'h01);
        wr(7, 8'hFF);
        expect_field("R10 write bit0=1 keeps flag", 7, 8'h01);
        wr(7, 8'h00);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 3'd7; wr_data_i = 8'h00; osc_fail_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; osc_fail_i = 1'b0;
        expect_field("R10 set beats clear", 7, 8'h01);
        rd(7, v);
        check("R9 status upper bits zero", v & 8'hFE, 8'h00);

        report();
    end
endmodule